// File: doc/BRIEF.md
# Two-Die Chained Test Access Register Path

This block holds the boundary-test register logic of a package that carries two (in general `DIES`) dies wired in series between the test data input and the test data output. One 16-state test-access controller, clocked by `tck` and steered by `tms`, drives every die. Each die owns a 4-bit instruction register with its own decoder, a one-stage bypass cell, a 32-bit identification shift register and a boundary-scan register of `BSR_LEN` cells that has a separate update stage.

An instruction scan therefore passes through all instruction registers in turn, so an instruction must be given once per die. A data scan passes through whichever data register each die's instruction selects. Die 0 sits next to `tdo`, and die `DIES-1` takes `tdi`. The block drives `tdo` on the falling edge of `tck` and leaves it floating outside the two shift states. For each die it reports whether the boundary cells drive the pins and whether the functional outputs must be disabled.

Top module: `dtap_chain`

## Requirements
- R1: The controller walks the standard 16-state graph on each rising `tck` edge using `tms`. This includes the pause and exit-2 states, which suspend a shift and then resume it with no bit lost. Five clocks with `tms` high reach Test-Logic-Reset from any state, and `trst_n` low forces that state at once.
- R2: One instruction scan is `IR_W*DIES` bits long (8 with the defaults). The first `IR_W` bits shifted in, taken LSB first, land in die 0, and the next `IR_W` bits land in die 1. No decoded output changes during the scan. The new instruction takes effect only on the clock edge that leaves Update-IR.
- R3: In Capture-IR each die loads the pattern 4'b0001. An 8-bit instruction scan therefore returns 8'h11, read LSB first.
- R4: Per-die opcode decoding works as follows. 4'h0 is boundary drive (external test) and 4'h1 is sample/preload; both connect the boundary-scan register. 4'h2 connects the identification register. 4'h3 is high-impedance and 4'hF is bypass; both connect the bypass cell. Every other code also connects the bypass cell.
- R5: The bypass cell is one stage long and loads 0 in Capture-DR. With both dies in bypass, a data scan returns two zeros and then `tdi` delayed by two clocks.
- R6: The identification word is 32'h0041_7067. Bits 31:28 hold version 0x0, bits 27:12 hold part code 0x0417, bits 11:1 hold manufacturer code 0x033, and bit 0 is 1. With both dies in identification mode, a data scan returns 64 bits: die 0's word first, each word LSB first.
- R7: The identification instruction is active in every die after `trst_n` is asserted and after Test-Logic-Reset is entered.
- R8: `tdo` changes on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR, and `tdo` is high-impedance at all other times.
- R9: Under either boundary instruction, Capture-DR loads `pin_in`, Shift-DR shifts the cells with bit 0 of die 0 nearest `tdo`, and Update-DR copies the cells to `pin_out`. `pin_out` keeps its value through instruction changes and Test-Logic-Reset.
- R10: `pin_drive[d]` is high only while die d holds the boundary-drive instruction. Sample/preload, identification and bypass leave it low.
- R11: `out_disable[d]` is high only while die d holds the high-impedance instruction.
- R12: Dies may hold different instructions. The data chain length is then the sum of the selected lengths. For example, die 0 in identification mode and die 1 in bypass give a 33-bit path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in, entering die DIES-1 |
| pin_in | input | DIES*BSR_LEN | Functional pin values captured by the boundary cells, die d at [d*BSR_LEN +: BSR_LEN] |
| tdo | output | 1 | Serial test data out from die 0, high-impedance when not shifting |
| tdo_oe | output | 1 | High while tdo is driven |
| pin_out | output | DIES*BSR_LEN | Boundary update stage, the values driven onto pins under boundary drive |
| pin_drive | output | DIES | Per die: boundary update stage owns the pins |
| out_disable | output | DIES | Per die: functional outputs forced off |

## Verification
The bench builds the block with two dies, 4-bit instruction registers and `BSR_LEN` = 5. With these values the whole boundary chain is 10 cells, so capture, preload and update of both dies fit in short scans. The full 64-bit identification readout, the 33-bit mixed chain and mixed per-die instructions such as drive on die 0 with sample on die 1 also become cheap to reach. A behavioural queue model of the serial path follows every clock, including scans that are paused and then resumed.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
   } tap_st_t;

   typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_t;

   localparam int unsigned OPC_EXTEST = 0;
   localparam int unsigned OPC_SAMPLE = 1;
   localparam int unsigned OPC_IDCODE = 2;
   localparam int unsigned OPC_HIGHZ  = 3;

   function automatic tap_st_t tap_step(tap_st_t s, logic m);
      tap_st_t n;
      case (s)
         ST_RESET:    n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:     n = m ? ST_DR_SEL : ST_IDLE;
         ST_DR_SEL:   n = m ? ST_IR_SEL : ST_DR_CAP;
         ST_DR_CAP:   n = m ? ST_DR_EX1 : ST_DR_SHIFT;
         ST_DR_SHIFT: n = m ? ST_DR_EX1 : ST_DR_SHIFT;
         ST_DR_EX1:   n = m ? ST_DR_UPD : ST_DR_PAUSE;
         ST_DR_PAUSE: n = m ? ST_DR_EX2 : ST_DR_PAUSE;
         ST_DR_EX2:   n = m ? ST_DR_UPD : ST_DR_SHIFT;
         ST_DR_UPD:   n = m ? ST_DR_SEL : ST_IDLE;
         ST_IR_SEL:   n = m ? ST_RESET  : ST_IR_CAP;
         ST_IR_CAP:   n = m ? ST_IR_EX1 : ST_IR_SHIFT;
         ST_IR_SHIFT: n = m ? ST_IR_EX1 : ST_IR_SHIFT;
         ST_IR_EX1:   n = m ? ST_IR_UPD : ST_IR_PAUSE;
         ST_IR_PAUSE: n = m ? ST_IR_EX2 : ST_IR_PAUSE;
         ST_IR_EX2:   n = m ? ST_IR_UPD : ST_IR_SHIFT;
         default:     n = m ? ST_DR_SEL : ST_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dtap_fsm.sv
module dtap_fsm
   import dtap_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_t st
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_RESET;
      else         st <= tap_step(st, tms);
   end

endmodule

// File: rtl/dtap_die.sv
module dtap_die
   import dtap_pkg::*;
#(
   parameter int unsigned IR_W    = 4,
   parameter int unsigned ID_W    = 32,
   parameter int unsigned BSR_LEN = 8,
   parameter logic [ID_W-1:0] ID_WORD = '0
) (
   input  logic               tck,
   input  logic               trst_n,
   input  tap_st_t            st,
   input  logic               si,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic               ir_so,
   output logic               dr_so,
   output logic [IR_W-1:0]    ir_now,
   output logic [BSR_LEN-1:0] pin_out,
   output logic               drive,
   output logic               disable_out
);

   localparam logic [IR_W-1:0] CAP_PAT    = IR_W'(1);
   localparam logic [IR_W-1:0] OP_EXTEST  = IR_W'(OPC_EXTEST);
   localparam logic [IR_W-1:0] OP_SAMPLE  = IR_W'(OPC_SAMPLE);
   localparam logic [IR_W-1:0] OP_IDCODE  = IR_W'(OPC_IDCODE);
   localparam logic [IR_W-1:0] OP_HIGHZ   = IR_W'(OPC_HIGHZ);

   logic [IR_W-1:0]    ir_sh;
   logic               byp_q;
   logic [ID_W-1:0]    id_sh;
   logic [BSR_LEN-1:0] bsr_sh;
   dr_path_t           path;

   // instruction register: capture pattern, shift toward die output, commit on update
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh  <= CAP_PAT;
         ir_now <= OP_IDCODE;
      end else begin
         case (st)
            ST_IR_CAP:   ir_sh <= CAP_PAT;
            ST_IR_SHIFT: ir_sh <= {si, ir_sh[IR_W-1:1]};
            default: ;
         endcase
         if (st == ST_RESET)       ir_now <= OP_IDCODE;
         else if (st == ST_IR_UPD) ir_now <= ir_sh;
      end
   end

   always_comb begin
      case (ir_now)
         OP_EXTEST, OP_SAMPLE: path = PATH_BSR;
         OP_IDCODE:            path = PATH_ID;
         default:              path = PATH_BYP;
      endcase
   end

   // data registers: only the selected one captures or shifts
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q   <= 1'b0;
         id_sh   <= ID_WORD;
         bsr_sh  <= '0;
         pin_out <= '0;
      end else begin
         if (st == ST_DR_CAP) begin
            case (path)
               PATH_BYP: byp_q  <= 1'b0;
               PATH_ID:  id_sh  <= ID_WORD;
               PATH_BSR: bsr_sh <= pin_in;
               default: ;
            endcase
         end else if (st == ST_DR_SHIFT) begin
            case (path)
               PATH_BYP: byp_q  <= si;
               PATH_ID:  id_sh  <= {si, id_sh[ID_W-1:1]};
               PATH_BSR: bsr_sh <= {si, bsr_sh[BSR_LEN-1:1]};
               default: ;
            endcase
         end
         if (st == ST_DR_UPD && path == PATH_BSR) pin_out <= bsr_sh;
      end
   end

   always_comb begin
      case (path)
         PATH_ID:  dr_so = id_sh[0];
         PATH_BSR: dr_so = bsr_sh[0];
         default:  dr_so = byp_q;
      endcase
   end

   assign ir_so       = ir_sh[0];
   assign drive       = (ir_now == OP_EXTEST);
   assign disable_out = (ir_now == OP_HIGHZ);

endmodule

// File: rtl/dtap_chain.sv
module dtap_chain
   import dtap_pkg::*;
#(
   parameter int unsigned DIES    = 2,
   parameter int unsigned IR_W    = 4,
   parameter int unsigned BSR_LEN = 8,
   parameter logic [3:0]  ID_VER  = 4'h0,
   parameter logic [15:0] ID_PART = 16'h0417,
   parameter logic [10:0] ID_MFR  = 11'h033
) (
   input  logic                      tck,
   input  logic                      trst_n,
   input  logic                      tms,
   input  logic                      tdi,
   input  logic [DIES*BSR_LEN-1:0]   pin_in,
   output logic                      tdo,
   output logic                      tdo_oe,
   output logic [DIES*BSR_LEN-1:0]   pin_out,
   output logic [DIES-1:0]           pin_drive,
   output logic [DIES-1:0]           out_disable
);

   localparam int unsigned ID_W = 32;
   localparam logic [ID_W-1:0] ID_WORD = {ID_VER, ID_PART, ID_MFR, 1'b1};

   if (DIES < 1) begin : g_bad_dies
      $error("dtap_chain: DIES must be at least 1");
   end
   if (IR_W < 2) begin : g_bad_irw
      $error("dtap_chain: IR_W must be at least 2");
   end
   if (BSR_LEN < 2) begin : g_bad_bsr
      $error("dtap_chain: BSR_LEN must be at least 2");
   end

   tap_st_t                 st;
   logic [DIES-1:0]         ir_so;
   logic [DIES-1:0]         dr_so;
   logic [DIES-1:0][IR_W-1:0] ir_now;
   logic                    tdo_q;

   dtap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   for (genvar d = 0; d < DIES; d++) begin : g_die
      logic si;
      if (d == DIES - 1) begin : g_head
         assign si = tdi;
      end else begin : g_link
         assign si = (st == ST_IR_SHIFT) ? ir_so[d+1] : dr_so[d+1];
      end

      dtap_die #(
         .IR_W    (IR_W),
         .ID_W    (ID_W),
         .BSR_LEN (BSR_LEN),
         .ID_WORD (ID_WORD)
      ) u_die (
         .tck         (tck),
         .trst_n      (trst_n),
         .st          (st),
         .si          (si),
         .pin_in      (pin_in[d*BSR_LEN +: BSR_LEN]),
         .ir_so       (ir_so[d]),
         .dr_so       (dr_so[d]),
         .ir_now      (ir_now[d]),
         .pin_out     (pin_out[d*BSR_LEN +: BSR_LEN]),
         .drive       (pin_drive[d]),
         .disable_out (out_disable[d])
      );
   end

   // output stage launched on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q  <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (st == ST_IR_SHIFT) || (st == ST_DR_SHIFT);
         tdo_q  <= (st == ST_IR_SHIFT) ? ir_so[0] : dr_so[0];
      end
   end

   assign tdo = tdo_oe ? tdo_q : 1'bz;

endmodule

// File: rtl/dtap_chain_chk.sv
module dtap_chain_chk
   import dtap_pkg::*;
#(
   parameter int unsigned DIES = 2,
   parameter int unsigned IR_W = 4
) (
   input logic                      tck,
   input logic                      trst_n,
   input tap_st_t                   st,
   input logic [DIES-1:0][IR_W-1:0] ir_now,
   input logic [DIES-1:0]           ir_so,
   input logic [DIES-1:0]           dr_so,
   input logic                      tdo_oe
);

   // R8: output enable window follows the shift states
   a_r8_oe_window: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == ((st == ST_IR_SHIFT) || (st == ST_DR_SHIFT)));

   for (genvar d = 0; d < DIES; d++) begin : g_die_chk
      // R2: active instruction moves only after Update-IR or reset state
      a_r2_update_only: assert property (@(posedge tck) disable iff (!trst_n)
         !$stable(ir_now[d]) |-> ($past(st) == ST_IR_UPD || $past(st) == ST_RESET));

      // R7: reset state selects identification
      a_r7_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
         (st == ST_RESET) |=> (ir_now[d] == IR_W'(OPC_IDCODE)));

      // R3: captured pattern puts a one nearest the output
      a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
         (st == ST_IR_CAP) |=> ir_so[d]);

      // R5: bypass cell captures zero
      a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
         ((st == ST_DR_CAP) && (ir_now[d] > IR_W'(OPC_IDCODE))) |=> !dr_so[d]);
   end

endmodule

bind dtap_chain dtap_chain_chk #(.DIES(DIES), .IR_W(IR_W)) u_chk (
   .tck    (tck),
   .trst_n (trst_n),
   .st     (st),
   .ir_now (ir_now),
   .ir_so  (ir_so),
   .dr_so  (dr_so),
   .tdo_oe (tdo_oe)
);

// File: tb/dtap_chain_tb_top.sv
`timescale 1ns/100ps
module dtap_chain_tb_top;
   import dtap_pkg::*;

   localparam int unsigned DIES = 2;
   localparam int unsigned BSR  = 5;
   localparam int unsigned PW   = DIES * BSR;
   localparam logic [31:0] IDW  = 32'h0041_7067;
   localparam logic [63:0] ID2  = {IDW, IDW};

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic [PW-1:0] pin_in = '0;
   wire           tdo;
   logic          tdo_oe;
   logic [PW-1:0] pin_out;
   logic [DIES-1:0] pin_drive;
   logic [DIES-1:0] out_disable;

   int total = 0;
   int bad   = 0;

   always #2.5 tck = ~tck;

   dtap_chain #(.DIES(DIES), .IR_W(4), .BSR_LEN(BSR)) dut_i (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
      .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
      .pin_drive(pin_drive), .out_disable(out_disable)
   );

   // ---------------- reference model ----------------
   tap_st_t       m_st = ST_RESET;
   int            m_ir [DIES];
   logic [PW-1:0] m_upd = '0;
   bit            q[$];

   function automatic tap_st_t ref_next(tap_st_t s, bit m);
      case (s)
         ST_RESET:    return m ? ST_RESET : ST_IDLE;
         ST_IDLE:     return m ? ST_DR_SEL : ST_IDLE;
         ST_DR_SEL:   return m ? ST_IR_SEL : ST_DR_CAP;
         ST_IR_SEL:   return m ? ST_RESET : ST_IR_CAP;
         ST_DR_CAP, ST_DR_SHIFT: return m ? ST_DR_EX1 : ST_DR_SHIFT;
         ST_IR_CAP, ST_IR_SHIFT: return m ? ST_IR_EX1 : ST_IR_SHIFT;
         ST_DR_EX1:   return m ? ST_DR_UPD : ST_DR_PAUSE;
         ST_IR_EX1:   return m ? ST_IR_UPD : ST_IR_PAUSE;
         ST_DR_PAUSE: return m ? ST_DR_EX2 : ST_DR_PAUSE;
         ST_IR_PAUSE: return m ? ST_IR_EX2 : ST_IR_PAUSE;
         ST_DR_EX2:   return m ? ST_DR_UPD : ST_DR_SHIFT;
         ST_IR_EX2:   return m ? ST_IR_UPD : ST_IR_SHIFT;
         default:     return m ? ST_DR_SEL : ST_IDLE;
      endcase
   endfunction

   function automatic int plen(int op);
      if (op <= 1) return BSR;
      if (op == 2) return 32;
      return 1;
   endfunction

   task automatic model_reset();
      m_st = ST_RESET;
      foreach (m_ir[d]) m_ir[d] = 2;
      m_upd = '0;
      q.delete();
   endtask

   task automatic model_edge(bit m, bit din);
      case (m_st)
         ST_RESET: foreach (m_ir[d]) m_ir[d] = 2;
         ST_IR_CAP: begin
            q.delete();
            for (int d = 0; d < DIES; d++)
               for (int b = 0; b < 4; b++) q.push_back(b == 0);
         end
         ST_IR_SHIFT, ST_DR_SHIFT: begin
            void'(q.pop_front());
            q.push_back(din);
         end
         ST_IR_UPD: begin
            for (int d = 0; d < DIES; d++) begin
               int v = 0;
               for (int b = 0; b < 4; b++) if (q[d*4+b]) v |= (1 << b);
               m_ir[d] = v;
            end
         end
         ST_DR_CAP: begin
            q.delete();
            for (int d = 0; d < DIES; d++) begin
               if (m_ir[d] <= 1)
                  for (int b = 0; b < BSR; b++) q.push_back(pin_in[d*BSR+b]);
               else if (m_ir[d] == 2)
                  for (int b = 0; b < 32; b++) q.push_back(IDW[b]);
               else
                  q.push_back(1'b0);
            end
         end
         ST_DR_UPD: begin
            int off = 0;
            for (int d = 0; d < DIES; d++) begin
               if (m_ir[d] <= 1)
                  for (int b = 0; b < BSR; b++) m_upd[d*BSR+b] = q[off+b];
               off += plen(m_ir[d]);
            end
         end
         default: ;
      endcase
      m_st = ref_next(m_st, m);
   endtask

   // ---------------- checking ----------------
   task automatic chk(bit ok, string tag, logic [79:0] act, logic [79:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_cycle();
      bit            exp_oe;
      logic [DIES-1:0] ed, ez;
      exp_oe = (m_st == ST_IR_SHIFT) || (m_st == ST_DR_SHIFT);
      chk(tdo_oe == exp_oe, "R8 tdo_oe window", 80'(tdo_oe), 80'(exp_oe));
      if (exp_oe) chk(tdo == q[0], "R8 tdo bit", 80'(tdo), 80'(q[0]));
      for (int d = 0; d < DIES; d++) begin
         ed[d] = (m_ir[d] == 0);
         ez[d] = (m_ir[d] == 3);
      end
      chk(pin_drive == ed, "R2 pin_drive timing", 80'(pin_drive), 80'(ed));
      chk(out_disable == ez, "R2 out_disable timing", 80'(out_disable), 80'(ez));
      chk(pin_out == m_upd, "R9 pin_out model", 80'(pin_out), 80'(m_upd));
   endtask

   task automatic tick(bit m, bit din);
      tms = m;
      tdi = din;
      @(posedge tck);
      model_edge(m, din);
      @(negedge tck);
      #1;
      compare_cycle();
   endtask

   task automatic scan(bit is_ir, int n, logic [79:0] vin, output logic [79:0] vout);
      vout = '0;
      tick(1, 0);
      if (is_ir) tick(1, 0);
      tick(0, 0);
      tick(0, 0);
      for (int i = 0; i < n; i++) begin
         vout[i] = tdo;
         tick(i == n - 1, vin[i]);
      end
      tick(1, 0);
      tick(0, 0);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [79:0] o;
      model_reset();
      repeat (3) @(negedge tck);
      #1;
      chk(tdo_oe == 1'b0, "R8 reset tdo_oe", 80'(tdo_oe), 80'(0));
      chk(pin_drive == '0 && out_disable == '0, "R7 reset outputs",
          80'({pin_drive, out_disable}), 80'(0));
      chk(pin_out == '0, "R9 reset pin_out", 80'(pin_out), 80'(0));
      trst_n = 1'b1;
      tick(0, 0);

      // identification right after reset
      scan(0, 64, '0, o);
      chk(o[63:0] == ID2, "R7 R6 idcode after reset", o, 80'(ID2));

      // both bypass
      scan(1, 8, 80'hFF, o);
      chk(o[7:0] == 8'h11, "R3 capture pattern", o, 80'h11);
      scan(0, 8, 80'hA5, o);
      chk(o[7:0] == 8'h94, "R5 bypass two zeros then data", o, 80'h94);

      // high impedance
      scan(1, 8, 80'h33, o);
      chk(o[7:0] == 8'h11, "R3 capture pattern again", o, 80'h11);
      chk(out_disable == 2'b11 && pin_drive == 2'b00, "R11 highz both dies",
          80'({out_disable, pin_drive}), 80'hC);
      scan(0, 3, 80'h7, o);
      chk(o[2:0] == 3'b100, "R4 highz uses bypass", o, 80'h4);

      // mixed: die0 identification, die1 bypass
      scan(1, 8, 80'hF2, o);
      chk(out_disable == 2'b00, "R11 cleared", 80'(out_disable), 80'(0));
      scan(0, 40, {80{1'b1}}, o);
      chk(o[39:0] == {7'h7F, 1'b0, IDW}, "R12 33-bit mixed chain", o, 80'({7'h7F, 1'b0, IDW}));

      // undefined code
      scan(1, 8, 80'h77, o);
      chk(out_disable == 2'b00 && pin_drive == 2'b00, "R4 undefined code outputs",
          80'({out_disable, pin_drive}), 80'(0));
      scan(0, 4, 80'hB, o);
      chk(o[3:0] == 4'hC, "R4 undefined code is bypass", o, 80'hC);

      // sample / preload
      pin_in = 10'h2D3;
      scan(1, 8, 80'h11, o);
      scan(0, 10, 80'h15A, o);
      chk(o[9:0] == 10'h2D3, "R9 sample capture", o, 80'h2D3);
      chk(pin_out == 10'h15A, "R9 preload update", 80'(pin_out), 80'h15A);
      chk(pin_drive == 2'b00, "R10 sample no drive", 80'(pin_drive), 80'(0));

      // boundary drive
      scan(1, 8, 80'h00, o);
      chk(pin_drive == 2'b11, "R10 extest drive", 80'(pin_drive), 80'h3);
      chk(pin_out == 10'h15A, "R9 preload kept", 80'(pin_out), 80'h15A);
      pin_in = 10'h0F0;
      scan(0, 10, 80'h3FF, o);
      chk(o[9:0] == 10'h0F0, "R9 extest capture", o, 80'h0F0);
      chk(pin_out == 10'h3FF, "R9 extest update", 80'(pin_out), 80'h3FF);

      // per-die mix of drive and sample
      scan(1, 8, 80'h10, o);
      chk(pin_drive == 2'b01, "R12 die0 drive die1 sample", 80'(pin_drive), 80'h1);

      // Test-Logic-Reset via TMS
      for (int i = 0; i < 5; i++) tick(1, 0);
      chk(pin_drive == 2'b00 && out_disable == 2'b00, "R7 tlr outputs",
          80'({pin_drive, out_disable}), 80'(0));
      chk(pin_out == 10'h3FF, "R9 update stage survives tlr", 80'(pin_out), 80'h3FF);
      tick(0, 0);
      scan(0, 64, '0, o);
      chk(o[63:0] == ID2, "R7 idcode after tlr", o, 80'(ID2));

      // paused data scan
      tick(1, 0);
      tick(0, 0);
      tick(0, 0);
      for (int i = 0; i < 4; i++) begin
         o[i] = tdo;
         tick(i == 3, 0);
      end
      chk(o[3:0] == IDW[3:0], "R6 first id bits", o, 80'(IDW[3:0]));
      tick(0, 0);
      tick(0, 0);
      chk(tdo_oe == 1'b0, "R1 pause holds off tdo", 80'(tdo_oe), 80'(0));
      tick(1, 0);
      tick(0, 0);
      chk(tdo_oe == 1'b1 && tdo == IDW[4], "R1 resume after pause",
          80'({tdo_oe, tdo}), 80'({1'b1, IDW[4]}));
      tick(1, 0);
      tick(1, 0);
      tick(0, 0);

      // asynchronous reset
      scan(1, 8, 80'hFF, o);
      trst_n = 1'b0;
      #3;
      model_reset();
      chk(tdo_oe == 1'b0 && pin_out == '0, "R7 trst clears", 80'({tdo_oe, pin_out}), 80'(0));
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      tick(0, 0);
      scan(0, 64, '0, o);
      chk(o[63:0] == ID2, "R7 idcode after trst", o, 80'(ID2));

      finish_run();
   end

endmodule